// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a 16-bit position count from two encoder lines and folds it into the range 0 to a programmable modulo value. When it is switched on it reads the two lines in one of two ways. In phase mode they are an A/B quadrature pair, and every legal edge on either line is one step. In count/direction mode a rising edge on line A is one step, and line B gives the sense of that step. Both lines pass through a two-flop synchronizer before any decoding takes place.

The outputs are the count, a direction bit that remembers the sense of the last step, and a sticky wrap flag with a companion bit. The companion bit tells whether the last wrap went past the top of the range or below the bottom. A one-cycle clear pulse drops the flag. If the clear pulse and a new wrap land in the same cycle, the wrap wins.

The decoder is a four-state machine. Its state is the last synchronized line pair {A,B}: `AB_00`, `AB_10`, `AB_11`, `AB_01`. On every clock the state takes the new line pair. A change of state is classed as one of four transitions: `MOVE_FWD` (one step along 00→10→11→01→00), `MOVE_BACK` (one step the other way round), `JUMP` (both lines changed at once), or `HOLD` (no change). In count/direction mode the same state register serves as the edge detector for line A.

Top module: `quad_position_counter`

## Requirements
- R1: After reset the count is 0, the direction bit is 0, and the wrap flag and the wrap-position bit are both 0.
- R2: While `enable` is 0, changes on the encoder lines leave the count, direction and flags unchanged. The decoder state still follows the lines, so turning `enable` on later causes no spurious step.
- R3: In phase mode (`cd_mode`=0), each single-line change along the {A,B} order 00→10→11→01→00 adds one to the count (A leads B). Each single-line change along the reverse order subtracts one.
- R4: In phase mode, a change of both lines in the same cycle (00↔11 or 10↔01) is ignored: the count and the direction bit keep their values.
- R5: In count/direction mode (`cd_mode`=1), each rising edge of A steps the count: up when B is 1, down when B is 0. Falling edges of A, and changes on B while A holds, do not step.
- R6: `dir_up` becomes 1 after an up step and 0 after a down step. It keeps its value while no step occurs.
- R7: An up step taken when the count is greater than or equal to `modulo` loads 0, sets `wrap_flag`, and sets `wrap_at_top` to 1.
- R8: A down step taken when the count is 0 loads `modulo`, sets `wrap_flag`, and sets `wrap_at_top` to 0.
- R9: `wrap_flag` stays 1 until `wrap_clear` is sampled high and then reads 0 after that edge. `wrap_at_top` changes only on a wrap, and a clear leaves it as it is.
- R10: When `wrap_clear` and a wrap fall on the same clock edge, `wrap_flag` remains 1.
- R11: A change on the encoder lines shows up in the count after the third rising clock edge that follows it. After the second edge the count is still unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Encoder line A (phase A, or count strobe) |
| enc_b | input | 1 | Encoder line B (phase B, or direction) |
| enable | input | 1 | Turns on decoding |
| cd_mode | input | 1 | 0: phase mode, 1: count/direction mode |
| modulo | input | 16 | Top of the count range |
| wrap_clear | input | 1 | One-cycle pulse that clears the wrap flag |
| count | output | 16 | Position count |
| dir_up | output | 1 | Sense of the last step, 1 = up |
| wrap_flag | output | 1 | Sticky wrap indication |
| wrap_at_top | output | 1 | Position of the last wrap: 1 = top, 0 = bottom |

## Verification
The wrap event and the flag clear can fall in the same cycle, and the set must win. The bench knows the three-edge latency from the encoder lines to the count. It places a count at `modulo`, changes a line, and raises `wrap_clear` for exactly the edge on which the step arrives. It then expects `wrap_flag` to read 1 with the count at 0. A separate clear, on an edge with no step, is expected to drop the flag and to leave `wrap_at_top` as it was.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

    // Decoder state: last synchronized line pair, bit 1 = A, bit 0 = B
    typedef enum logic [1:0] {
        AB_00 = 2'b00,
        AB_01 = 2'b01,
        AB_11 = 2'b11,
        AB_10 = 2'b10
    } ab_state_e;

    // Classification of one state change
    typedef enum logic [1:0] {
        HOLD      = 2'd0,
        MOVE_FWD  = 2'd1,
        MOVE_BACK = 2'd2,
        JUMP      = 2'd3
    } ab_move_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = chain_q[LAST];
    end

endmodule

// File: rtl/qdc_step_fsm.sv
module qdc_step_fsm
    import qdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       cd_mode,
    input  logic [1:0] ab_sync,
    output step_t      step
);

    ab_state_e state_q;
    ab_state_e state_d;
    ab_move_e  move;

    assign state_d = ab_state_e'(ab_sync);

    // State register: follows the lines every cycle, enabled or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AB_00;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition classification for phase mode
    always_comb begin
        move = HOLD;
        unique case (state_q)
            AB_00: begin
                if (state_d == AB_10)      move = MOVE_FWD;
                else if (state_d == AB_01) move = MOVE_BACK;
                else if (state_d == AB_11) move = JUMP;
            end
            AB_10: begin
                if (state_d == AB_11)      move = MOVE_FWD;
                else if (state_d == AB_00) move = MOVE_BACK;
                else if (state_d == AB_01) move = JUMP;
            end
            AB_11: begin
                if (state_d == AB_01)      move = MOVE_FWD;
                else if (state_d == AB_10) move = MOVE_BACK;
                else if (state_d == AB_00) move = JUMP;
            end
            AB_01: begin
                if (state_d == AB_00)      move = MOVE_FWD;
                else if (state_d == AB_11) move = MOVE_BACK;
                else if (state_d == AB_10) move = JUMP;
            end
            default: move = HOLD;
        endcase
    end

    // Output process: step request per mode
    always_comb begin
        step = '0;
        if (enable) begin
            if (cd_mode) begin
                if (!state_q[1] && state_d[1]) begin
                    step.up = state_d[0];
                    step.dn = !state_d[0];
                end
            end else begin
                step.up = (move == MOVE_FWD);
                step.dn = (move == MOVE_BACK);
            end
        end
    end

    // R4: a two-line change never yields a step in phase mode
    p_jump_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_mode && (state_q[1] != ab_sync[1]) && (state_q[0] != ab_sync[0]))
        |-> (step == '0));

    // R5: falling A or static A gives no step in count/direction mode
    p_cd_no_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_mode && !(!state_q[1] && ab_sync[1])) |-> (step == '0));

    // R2: nothing moves while disabled
    p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (step == '0));

endmodule

// File: rtl/qdc_position.sv
module qdc_position
    import qdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step,
    input  logic [CNT_W-1:0] modulo,
    input  logic             wrap_clear,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             wrap_flag,
    output logic             wrap_at_top
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic top_hit;
    logic bot_hit;

    assign top_hit = step.up && (count >= modulo);
    assign bot_hit = step.dn && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            dir_up <= 1'b0;
        end else if (step.up) begin
            dir_up <= 1'b1;
            count  <= top_hit ? '0 : count + ONE;
        end else if (step.dn) begin
            dir_up <= 1'b0;
            count  <= bot_hit ? modulo : count - ONE;
        end
    end

    // Wrap flag: a set outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrap_flag   <= 1'b0;
            wrap_at_top <= 1'b0;
        end else if (top_hit || bot_hit) begin
            wrap_flag   <= 1'b1;
            wrap_at_top <= top_hit;
        end else if (wrap_clear) begin
            wrap_flag   <= 1'b0;
        end
    end

    p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({step.up, step.dn}) <= 1);

    p_dir_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step.up |=> dir_up);

    p_dir_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step.dn |=> !dir_up);

    p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |=> ($stable(dir_up) && $stable(count)));

    p_top_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step.up && count >= modulo) |=> (count == '0 && wrap_flag && wrap_at_top));

    p_bot_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step.dn && count == '0) |=> (count == $past(modulo) && wrap_flag && !wrap_at_top));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_flag && !wrap_clear) |=> wrap_flag);

    p_pos_bit_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |=> $stable(wrap_at_top));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_clear && (top_hit || bot_hit)) |=> wrap_flag);

endmodule

// File: rtl/quad_position_counter.sv
module quad_position_counter
    import qdc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enable,
    input  logic             cd_mode,
    input  logic [CNT_W-1:0] modulo,
    input  logic             wrap_clear,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             wrap_flag,
    output logic             wrap_at_top
);

    logic [1:0] ab_sync;
    step_t      step;

    qdc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({enc_a, enc_b}),
        .dout  (ab_sync)
    );

    qdc_step_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .cd_mode (cd_mode),
        .ab_sync (ab_sync),
        .step    (step)
    );

    qdc_position #(
        .CNT_W (CNT_W)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .modulo      (modulo),
        .wrap_clear  (wrap_clear),
        .count       (count),
        .dir_up      (dir_up),
        .wrap_flag   (wrap_flag),
        .wrap_at_top (wrap_at_top)
    );

    // R2: disabled decoder leaves the outputs where they are
    p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(count) && $stable(dir_up) && $stable(wrap_at_top)));

    // R1: reset values observed right after release
    p_reset_vals_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (count == '0 && !dir_up && !wrap_flag && !wrap_at_top));

endmodule

// File: tb/quad_position_counter_test.sv
module quad_position_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_a = 1'b0;
    logic          enc_b = 1'b0;
    logic          enable = 1'b0;
    logic          cd_mode = 1'b0;
    logic [CW-1:0] modulo = '0;
    logic          wrap_clear = 1'b0;
    logic [CW-1:0] count;
    logic          dir_up;
    logic          wrap_flag;
    logic          wrap_at_top;

    quad_position_counter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enc_a       (enc_a),
        .enc_b       (enc_b),
        .enable      (enable),
        .cd_mode     (cd_mode),
        .modulo      (modulo),
        .wrap_clear  (wrap_clear),
        .count       (count),
        .dir_up      (dir_up),
        .wrap_flag   (wrap_flag),
        .wrap_at_top (wrap_at_top)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int       n_tests = 0;
    int       n_fail = 0;
    bit       done = 1'b0;
    int       m_cnt = 0;
    bit       m_dir = 1'b0;
    bit       m_ovf = 1'b0;
    bit       m_top = 1'b0;
    bit [1:0] m_prev = 2'b00;

    // Position of {A,B} along the forward order 00,10,11,01
    function automatic int pidx(bit [1:0] v);
        case (v)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_move(bit up);
        int mv = int'(modulo);
        if (up) begin
            m_dir = 1'b1;
            if (m_cnt >= mv) begin
                m_cnt = 0; m_ovf = 1'b1; m_top = 1'b1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end else begin
            m_dir = 1'b0;
            if (m_cnt == 0) begin
                m_cnt = mv; m_ovf = 1'b1; m_top = 1'b0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    endtask

    task automatic model_lines(bit [1:0] nv);
        if (enable) begin
            if (!cd_mode) begin
                int d = (pidx(nv) - pidx(m_prev) + 4) % 4;
                if (d == 1) model_move(1'b1);
                else if (d == 3) model_move(1'b0);
            end else if (!m_prev[1] && nv[1]) begin
                model_move(nv[0]);
            end
        end
        m_prev = nv;
    endtask

    task automatic check_all(string tag);
        chk({tag, " count"}, int'(count), m_cnt);
        chk({tag, " dir_up"}, int'(dir_up), int'(m_dir));
        chk({tag, " wrap_flag"}, int'(wrap_flag), int'(m_ovf));
        chk({tag, " wrap_at_top"}, int'(wrap_at_top), int'(m_top));
    endtask

    task automatic drive(bit a, bit b, string tag);
        @(negedge clk);
        enc_a = a;
        enc_b = b;
        model_lines({a, b});
        repeat (4) @(negedge clk);
        check_all(tag);
    endtask

    task automatic clear_flag(string tag);
        @(negedge clk);
        wrap_clear = 1'b1;
        @(negedge clk);
        wrap_clear = 1'b0;
        m_ovf = 1'b0;
        check_all(tag);
    endtask

    // Step forward or back once in phase mode from the current lines
    task automatic phase_step(bit fwd, string tag);
        int       i = (pidx(m_prev) + (fwd ? 1 : 3)) % 4;
        bit [1:0] nv;
        case (i)
            0: nv = 2'b00;
            1: nv = 2'b10;
            2: nv = 2'b11;
            default: nv = 2'b01;
        endcase
        drive(nv[1], nv[0], tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        modulo = 16'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        enable = 1'b1;

        // R11: latency of three edges
        @(negedge clk);
        enc_a = 1'b1;
        model_lines(2'b10);
        @(negedge clk);
        @(negedge clk);
        chk("R11 count after two edges", int'(count), 0);
        @(negedge clk);
        chk("R11 count after three edges", int'(count), m_cnt);
        repeat (2) @(negedge clk);

        // R3/R7: forward phase sweep over several periods
        for (int k = 0; k < 24; k++) phase_step(1'b1, "R3 R7 forward");
        clear_flag("R9 clear after top wrap");
        // R3/R8: reverse sweep crossing the bottom
        for (int k = 0; k < 24; k++) phase_step(1'b0, "R3 R8 reverse");

        // R9: clear keeps wrap_at_top
        clear_flag("R9 clear keeps position bit");

        // R4: two-line jumps from every state
        for (int k = 0; k < 4; k++) begin
            drive(~m_prev[1], ~m_prev[0], "R4 jump ignored");
            phase_step(1'b1, "R4 step after jump");
        end

        // Modulo sweep, small ranges including 0
        for (int mv = 0; mv < 4; mv++) begin
            @(negedge clk);
            modulo = CW'(mv);
            for (int k = 0; k < 6; k++) phase_step(1'b1, "R7 modulo sweep up");
            for (int k = 0; k < 6; k++) phase_step(1'b0, "R8 modulo sweep down");
        end
        modulo = 16'd5;

        // R2: disabled, lines move, outputs hold
        @(negedge clk);
        enable = 1'b0;
        for (int k = 0; k < 5; k++) phase_step(1'b1, "R2 disabled hold");
        @(negedge clk);
        enable = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R2 no step on re-enable");

        // R5/R6: count/direction mode
        @(negedge clk);
        cd_mode = 1'b1;
        drive(1'b0, 1'b1, "R5 setup");
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b1, "R5 R6 rising A with B high");
            drive(1'b0, 1'b1, "R5 falling A no step");
        end
        drive(1'b0, 1'b0, "R5 B change no step");
        drive(1'b0, 1'b1, "R5 B change no step");
        drive(1'b1, 1'b1, "R5 up step");
        drive(1'b1, 1'b0, "R6 B change with A high holds");
        drive(1'b0, 1'b0, "R5 falling A no step");
        for (int k = 0; k < 9; k++) begin
            drive(1'b1, 1'b0, "R5 R6 rising A with B low");
            drive(1'b0, 1'b0, "R5 falling A no step");
        end

        // R10: clear and wrap on the same edge
        clear_flag("R9 clear before R10");
        @(negedge clk);
        modulo = CW'(m_cnt);
        @(negedge clk);
        enc_a = 1'b1;
        enc_b = 1'b1;
        model_lines(2'b11);
        @(negedge clk);
        @(negedge clk);
        wrap_clear = 1'b1;
        @(negedge clk);
        wrap_clear = 1'b0;
        chk("R10 flag set wins over clear", int'(wrap_flag), 1);
        chk("R10 count wrapped", int'(count), 0);
        chk("R10 top position", int'(wrap_at_top), 1);
        clear_flag("R9 clear alone");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule